// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors kept in a local buffer memory that is 16 bits wide. Each descriptor points at one data buffer. A frame is a chain of one or more consecutive descriptors: a start marker on the first and an end marker on the last. The engine gathers the bytes of every buffer in the chain and sends them out as a byte stream with a valid/ready handshake. The final byte of the frame is flagged. After each descriptor is used, the engine hands it back to software by clearing its ownership flag.

Software fills descriptors, sets their ownership flags and then pulses a demand input. When transmission is enabled, a pending demand starts a pass. The pass continues frame after frame until it reaches a descriptor that is not ready, or until it has used one full lap of the ring. Before any byte of a frame leaves the block, the engine scans the whole chain ahead. So a frame whose end has not yet been handed over produces no output, and its descriptors stay untouched. When a frame completes, a one-cycle interrupt pulse is raised.

Top module: `txd_ring_engine`

## Requirements
- R1: Descriptor n of the ring occupies memory words (ring_base/2)+4n+0..3. The buffer byte address is word0 in bits 15:0 and word1 bits 7:0 in bits 23:16. Bytes are little-endian: an even byte address selects bits 7:0 of its word and an odd one selects bits 15:8.
- R2: The buffer length is 4096 minus word2 bits 11:0. A descriptor is not ready if word2 bits 15:12 are not all ones, or if the length is below 12 or above 1900. A pass ends at a descriptor that is not ready, and that descriptor is left unchanged.
- R3: A descriptor whose ownership flag (word1 bit 15) is clear is not ready and ends the pass.
- R4: A frame begins at a descriptor with the start flag (word1 bit 9) and ends at the first one with the end flag (word1 bit 8). Its bytes are the buffers of the chain in ring order. Only the final byte of the frame is sent with tx_last_o high.
- R5: Every consumed descriptor gets word1 written back with bit 15 cleared and all other bits kept. Words 0, 2 and 3 are not altered.
- R6: tx_irq_o pulses for exactly one cycle once per completed frame, right after the end descriptor is written back.
- R7: The ring index moves to the next descriptor and wraps from ring_len-1 to 0. It persists from one pass to the next. A pass consumes at most ring_len descriptors.
- R8: A demand pulse is remembered until tx_en_i is high, and only then does a pass start. After reset no memory access, output byte or interrupt occurs.
- R9: If the descriptor at the current index is ready but lacks the start flag, the pass ends and that descriptor is left unchanged.
- R10: If a start flag appears inside a chain before the end flag, the earlier descriptors of that chain are handed back (ownership cleared) without emitting any byte. A new frame then begins at the new start.
- R11: If a chain meets a descriptor that is not ready before its end flag, no byte of that frame is emitted and none of its descriptors is modified.
- R12: While tx_valid_o is high and tx_ready_i is low, tx_valid_o, tx_data_o and tx_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en_i | input | 1 | Allows a pending demand to start a pass |
| demand_i | input | 1 | One-cycle request to scan the ring |
| ring_base_i | input | 24 | Byte address of descriptor 0 (even) |
| ring_len_i | input | 7 | Number of descriptors in the ring, 1 to RING_MAX |
| mem_req_o | output | 1 | Buffer memory access strobe |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 23 | Word address into buffer memory |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read strobe |
| tx_data_o | output | 8 | Outgoing frame byte |
| tx_valid_o | output | 1 | tx_data_o holds a byte |
| tx_last_o | output | 1 | Byte is the final one of its frame |
| tx_ready_i | input | 1 | Sink accepts the byte this cycle |
| tx_irq_o | output | 1 | One-cycle pulse per completed frame |

## Verification
The assertions assume that ring_base_i and ring_len_i stay stable and nonzero while a pass runs, and that software does not rewrite descriptors during a pass. The bench changes those inputs and descriptor words only between passes, while the engine is quiet, with tx_en_i low or no demand given. Buffer memory returns read data exactly one cycle after a read strobe. The bench memory model keeps to that, and it places every buffer inside the modelled address range.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int BUF_AW   = 24;   // byte address width of a buffer
  localparam int WORD_W   = 16;
  localparam int OWN_BIT  = 15;
  localparam int STP_BIT  = 9;
  localparam int ENP_BIT  = 8;
  localparam int LEN_W    = 13;   // holds 4096 - field
  localparam int LEN_SPAN = 4096;
  localparam int LEN_MIN  = 12;
  localparam int LEN_MAX  = 1900;
  localparam int CNT_W    = 11;   // enough for LEN_MAX

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SCAN_W1,
    ST_SCAN_W2,
    ST_SCAN_CHK,
    ST_DROP_RD,
    ST_DROP_WR,
    ST_LD_W0,
    ST_LD_W1,
    ST_LD_W2,
    ST_LD_LEN,
    ST_BYTE_RD,
    ST_BYTE_CAP,
    ST_BYTE_OUT,
    ST_WB
  } txd_state_e;
endpackage

// File: rtl/txd_rst_sync.sv
module txd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/txd_desc_decode.sv
module txd_desc_decode
  import txd_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_w,
  input  logic [WORD_W-1:0] cnt_w,
  output logic              own_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              ready_o,
  output logic [LEN_W-1:0]  len_o
);
  logic marker_ok;
  logic len_ok;

  always_comb begin
    own_o     = ctl_w[OWN_BIT];
    sop_o     = ctl_w[STP_BIT];
    eop_o     = ctl_w[ENP_BIT];
    len_o     = LEN_W'(LEN_SPAN) - {1'b0, cnt_w[11:0]};
    marker_ok = &cnt_w[15:12];
    len_ok    = (len_o >= LEN_W'(LEN_MIN)) && (len_o <= LEN_W'(LEN_MAX));
    ready_o   = own_o && marker_ok && len_ok;
  end
endmodule

// File: rtl/txd_byte_stage.sv
module txd_byte_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       last_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] byte_o,
  output logic       last_o,
  output logic       fire_o
);
  logic       vld_q, vld_d;
  logic [7:0] dat_q, dat_d;
  logic       lst_q, lst_d;

  assign fire_o = vld_q && ready_i;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    lst_d = lst_q;
    if (fire_o) vld_d = 1'b0;
    if (load_i) begin
      vld_d = 1'b1;
      dat_d = byte_i;
      lst_d = last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= 8'h00;
      lst_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load_i) begin
        dat_q <= dat_d;
        lst_q <= lst_d;
      end
    end
  end

  assign valid_o = vld_q;
  assign byte_o  = dat_q;
  assign last_o  = lst_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o) && $stable(last_o))); // R12
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
  import txd_pkg::*;
#(
  parameter int RING_MAX = 64,
  localparam int IDX_W   = $clog2(RING_MAX),
  localparam int AW      = BUF_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_i,
  input  logic              demand_i,
  input  logic [AW-1:0]     ring_base_i,
  input  logic [IDX_W:0]    ring_len_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-2:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic              tx_irq_o
);
  localparam int SUM_W = IDX_W + 2;

  logic srst_n;
  txd_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  txd_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  scan_q, scan_d;
  logic [IDX_W:0]    chain_q, chain_d;
  logic [IDX_W:0]    lap_q, lap_d;
  logic [WORD_W-1:0] w1_q, w1_d;
  logic [WORD_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0]  blen_q, blen_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic              hold_q, hold_d;
  logic              irq_q, irq_d;
  logic              pend_q, pend_d;

  logic              d_own, d_sop, d_eop, d_ready;
  logic [LEN_W-1:0]  d_len;
  logic [1:0]        wsel;
  logic              sel_scan, byte_acc, ld;
  logic              fire;
  logic [AW-1:0]     baddr;
  logic [AW-2:0]     desc_wa;
  logic [IDX_W-1:0]  sel_idx;
  logic [SUM_W-1:0]  used_sum;
  logic              at_last;
  logic [7:0]        pick_byte;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] i,
                                                 input logic [IDX_W:0]   len);
    logic [IDX_W:0] p;
    p = {1'b0, i} + 1'b1;
    return (p >= len) ? '0 : p[IDX_W-1:0];
  endfunction

  txd_desc_decode u_dec (
    .ctl_w(w1_q), .cnt_w(mem_rdata_i),
    .own_o(d_own), .sop_o(d_sop), .eop_o(d_eop), .ready_o(d_ready), .len_o(d_len)
  );

  txd_byte_stage u_out (
    .clk(clk), .rst_n(srst_n), .load_i(ld), .byte_i(pick_byte), .last_i(w1_q[ENP_BIT] && at_last),
    .ready_i(tx_ready_i), .valid_o(tx_valid_o), .byte_o(tx_data_o), .last_o(tx_last_o), .fire_o(fire)
  );

  assign used_sum  = SUM_W'(lap_q) + SUM_W'(chain_q);
  assign at_last   = (bcnt_q == blen_q - 1'b1);
  assign baddr     = {w1_q[7:0], lo_q} + AW'(bcnt_q);
  assign pick_byte = baddr[0] ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
  assign sel_idx   = sel_scan ? scan_q : idx_q;
  assign desc_wa   = ring_base_i[AW-1:1] + (AW-1)'({sel_idx, wsel});
  assign mem_addr_o = byte_acc ? baddr[AW-1:1] : desc_wa;

  always_comb begin
    st_d = st_q;       idx_d = idx_q;     scan_d = scan_q;
    chain_d = chain_q; lap_d = lap_q;     w1_d = w1_q;
    lo_d = lo_q;       blen_d = blen_q;   bcnt_d = bcnt_q;
    hold_d = hold_q;   irq_d = 1'b0;
    pend_d = pend_q | demand_i;
    mem_req_o = 1'b0;  mem_we_o = 1'b0;   mem_wdata_o = '0;
    wsel = 2'd1;       sel_scan = 1'b0;   byte_acc = 1'b0;  ld = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (pend_q && tx_en_i) begin
          pend_d  = demand_i;
          lap_d   = '0;
          chain_d = '0;
          scan_d  = idx_q;
          st_d    = ST_SCAN_W1;
        end
      end
      ST_SCAN_W1: begin
        if (used_sum >= SUM_W'(ring_len_i)) begin
          st_d = ST_IDLE;
        end else begin
          mem_req_o = 1'b1; sel_scan = 1'b1; wsel = 2'd1;
          st_d = ST_SCAN_W2;
        end
      end
      ST_SCAN_W2: begin
        w1_d = mem_rdata_i;
        mem_req_o = 1'b1; sel_scan = 1'b1; wsel = 2'd2;
        st_d = ST_SCAN_CHK;
      end
      ST_SCAN_CHK: begin
        if (!d_ready || (chain_q == '0 && !d_sop)) begin
          st_d = ST_IDLE;
        end else if (chain_q != '0 && d_sop) begin
          hold_d = d_eop;
          st_d   = ST_DROP_RD;
        end else begin
          chain_d = chain_q + 1'b1;
          scan_d  = ring_next(scan_q, ring_len_i);
          st_d    = d_eop ? ST_LD_W0 : ST_SCAN_W1;
        end
      end
      ST_DROP_RD: begin
        mem_req_o = 1'b1; wsel = 2'd1;
        st_d = ST_DROP_WR;
      end
      ST_DROP_WR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; wsel = 2'd1;
        mem_wdata_o = mem_rdata_i & ~(WORD_W'(1) << OWN_BIT);
        idx_d = ring_next(idx_q, ring_len_i);
        lap_d = lap_q + 1'b1;
        if (chain_q == (IDX_W+1)'(1)) begin
          chain_d = (IDX_W+1)'(1);
          scan_d  = ring_next(scan_q, ring_len_i);
          st_d    = hold_q ? ST_LD_W0 : ST_SCAN_W1;
        end else begin
          chain_d = chain_q - 1'b1;
          st_d    = ST_DROP_RD;
        end
      end
      ST_LD_W0: begin
        mem_req_o = 1'b1; wsel = 2'd0;
        st_d = ST_LD_W1;
      end
      ST_LD_W1: begin
        lo_d = mem_rdata_i;
        mem_req_o = 1'b1; wsel = 2'd1;
        st_d = ST_LD_W2;
      end
      ST_LD_W2: begin
        w1_d = mem_rdata_i;
        mem_req_o = 1'b1; wsel = 2'd2;
        st_d = ST_LD_LEN;
      end
      ST_LD_LEN: begin
        blen_d = d_len[CNT_W-1:0];
        bcnt_d = '0;
        st_d   = ST_BYTE_RD;
      end
      ST_BYTE_RD: begin
        mem_req_o = 1'b1; byte_acc = 1'b1;
        st_d = ST_BYTE_CAP;
      end
      ST_BYTE_CAP: begin
        ld   = 1'b1;
        st_d = ST_BYTE_OUT;
      end
      ST_BYTE_OUT: begin
        if (fire) begin
          if (at_last) begin
            st_d = ST_WB;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
            st_d   = ST_BYTE_RD;
          end
        end
      end
      ST_WB: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; wsel = 2'd1;
        mem_wdata_o = w1_q & ~(WORD_W'(1) << OWN_BIT);
        idx_d   = ring_next(idx_q, ring_len_i);
        lap_d   = lap_q + 1'b1;
        chain_d = chain_q - 1'b1;
        if (w1_q[ENP_BIT]) begin
          irq_d = 1'b1;
          st_d  = ST_SCAN_W1;
        end else begin
          st_d  = ST_LD_W0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= ST_IDLE;  idx_q <= '0;  scan_q <= '0;  chain_q <= '0;
      lap_q <= '0;      w1_q <= '0;   lo_q <= '0;    blen_q <= '0;
      bcnt_q <= '0;     hold_q <= 1'b0; irq_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      st_q <= st_d;  idx_q <= idx_d;  scan_q <= scan_d;  chain_q <= chain_d;
      lap_q <= lap_d; w1_q <= w1_d;   lo_q <= lo_d;      blen_q <= blen_d;
      bcnt_q <= bcnt_d; hold_q <= hold_d; irq_q <= irq_d; pend_q <= pend_d;
    end
  end

  assign tx_irq_o = irq_q;

  AST_WB_OWN_CLR: assert property (@(posedge clk) disable iff (!srst_n)
    mem_we_o |-> !mem_wdata_o[OWN_BIT]); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    tx_irq_o |=> !tx_irq_o); // R6
  AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (!srst_n)
    tx_irq_o |-> ($past(mem_we_o) && $past(mem_wdata_o[ENP_BIT]))); // R6
  AST_LAP_BOUND: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q != ST_IDLE) |-> (used_sum <= SUM_W'(ring_len_i))); // R7
  AST_START_GATED: assert property (@(posedge clk) disable iff (!srst_n)
    ((st_q != ST_IDLE) && $past(st_q == ST_IDLE)) |-> $past(tx_en_i)); // R8
  AST_NO_OUT_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_IDLE) |-> (!tx_valid_o && !mem_req_o)); // R8
endmodule

// File: tb/sim_txd_ring_engine.sv
module sim_txd_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_en, demand;
  logic [23:0] ring_base;
  logic [6:0]  ring_len;
  logic        mem_req, mem_we;
  logic [22:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_irq;
  logic        tx_ready = 1'b0;

  always #2.5 clk = ~clk;

  txd_ring_engine u0 (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .demand_i(demand),
    .ring_base_i(ring_base), .ring_len_i(ring_len),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .tx_irq_o(tx_irq)
  );

  // descriptor region words 0..1023 stored; data region computed
  logic [15:0] dmem [0:1023];
  logic [15:0] exp_mem [0:1023];
  logic        bw_en = 1'b0;
  logic [9:0]  bw_addr = '0;
  logic [15:0] bw_data = '0;
  int          salt = 0;

  function automatic logic [15:0] dat(input int w, input int s);
    return 16'((w * 40503) ^ (s * 965) ^ (w >> 3));
  endfunction

  always @(posedge clk) begin
    if (bw_en) dmem[bw_addr] <= bw_data;
    if (mem_req) begin
      if (mem_we) begin
        if (mem_addr[11:10] == 2'b00) dmem[mem_addr[9:0]] <= mem_wdata;
      end else if (mem_addr[11:10] == 2'b00) begin
        mem_rdata <= dmem[mem_addr[9:0]];
      end else begin
        mem_rdata <= dat(int'(mem_addr[11:0]), salt);
      end
    end
  end

  // monitor: sets ready, records handshakes and interrupts
  int   ready_mode = 0;
  logic [8:0] rx_q[$];
  int   irq_cnt = 0;
  int   req_cnt = 0;
  always @(negedge clk) begin
    tx_ready = (ready_mode == 1) ? 1'b1 : (($urandom % 4) != 0);
    if (tx_valid && tx_ready) rx_q.push_back({tx_last, tx_data});
    if (tx_irq) irq_cnt = irq_cnt + 1;
    if (mem_req) req_cnt = req_cnt + 1;
  end

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 190000) begin
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
    end
  end

  // reference state
  int m_idx = 0;
  int m_irq = 0;
  logic [8:0] exp_q[$];
  int rx_base = 0, irq_base = 0;
  localparam int RBASE = 256;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int dw(input int n, input int w);
    return RBASE / 2 + 4 * n + w;
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    int w;
    logic [15:0] v;
    w = (a >> 1) & 4095;
    v = (w < 1024) ? exp_mem[w] : dat(w, salt);
    return a[0] ? v[15:8] : v[7:0];
  endfunction

  task automatic put_word(input int a, input logic [15:0] v);
    exp_mem[a] = v;
    @(negedge clk);
    bw_en = 1'b1; bw_addr = 10'(a); bw_data = v;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic set_desc(input int n, input int baddr, input int len,
                          input bit own, input bit stp, input bit enp, input bit mark);
    put_word(dw(n, 0), baddr[15:0]);
    put_word(dw(n, 1), {own, 5'b0, stp, enp, baddr[23:16]});
    put_word(dw(n, 2), {mark ? 4'hF : 4'h0, 12'(4096 - len)});
    put_word(dw(n, 3), 16'(n * 4369 ^ 2570));
  endtask

  task automatic set_own(input int n);
    logic [15:0] v;
    v = exp_mem[dw(n, 1)];
    v[15] = 1'b1;
    put_word(dw(n, 1), v);
  endtask

  task automatic do_reset(input int len, input int s);
    tx_en = 1'b0; demand = 1'b0;
    rst_n = 1'b0;
    ring_base = 24'(RBASE);
    ring_len = 7'(len);
    salt = s;
    m_idx = 0; m_irq = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rx_base = rx_q.size();
    irq_base = irq_cnt;
  endtask

  task automatic model_pass();
    int cons, n, L, d, len, ba, k;
    logic [15:0] w1, w2;
    bit done, rdy;
    L = int'(ring_len);
    cons = 0; done = 0;
    while (!done) begin
      n = 0;
      forever begin
        if (cons + n >= L) begin done = 1; break; end
        d  = (m_idx + n) % L;
        w1 = exp_mem[dw(d, 1)];
        w2 = exp_mem[dw(d, 2)];
        len = 4096 - int'(w2[11:0]);
        rdy = w1[15] && (w2[15:12] == 4'hF) && len >= 12 && len <= 1900;
        if (!rdy) begin done = 1; break; end
        if (n == 0 && !w1[9]) begin done = 1; break; end
        if (n > 0 && w1[9]) begin
          for (int j = 0; j < n; j++) exp_mem[dw((m_idx + j) % L, 1)][15] = 1'b0;
          m_idx = (m_idx + n) % L; cons += n; n = 0;
        end
        n++;
        if (w1[8]) begin
          for (int j = 0; j < n; j++) begin
            k  = (m_idx + j) % L;
            ba = int'(exp_mem[dw(k, 0)]) + (int'(exp_mem[dw(k, 1)][7:0]) << 16);
            len = 4096 - int'(exp_mem[dw(k, 2)][11:0]);
            for (int b = 0; b < len; b++)
              exp_q.push_back({(j == n - 1) && (b == len - 1), rd_byte(ba + b)});
            exp_mem[dw(k, 1)][15] = 1'b0;
          end
          m_idx = (m_idx + n) % L; cons += n; m_irq++;
          break;
        end
      end
    end
  endtask

  task automatic pulse_demand();
    @(negedge clk); demand = 1'b1;
    @(negedge clk); demand = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      q = (!mem_req && !tx_valid) ? q + 1 : 0;
    end
  endtask

  task automatic compare(input string tag);
    int got_n;
    got_n = rx_q.size() - rx_base;
    check(got_n == exp_q.size(), tag, "byte count", got_n, exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_n; i++)
      check(rx_q[rx_base + i] == exp_q[i], tag, "byte {last,data}", rx_q[rx_base + i], exp_q[i]);
    check((irq_cnt - irq_base) == m_irq, {tag, " R6"}, "irq count", irq_cnt - irq_base, m_irq);
    for (int n = 0; n < int'(ring_len); n++)
      for (int w = 0; w < 4; w++)
        check(dmem[dw(n, w)] == exp_mem[dw(n, w)], {tag, " R5"}, "descriptor word",
              dmem[dw(n, w)], exp_mem[dw(n, w)]);
  endtask

  task automatic run_pass(input string tag);
    pulse_demand();
    wait_idle();
    model_pass();
    compare(tag);
  endtask

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; demand = 1'b0; ring_base = '0; ring_len = 7'd1;

    // reset state, then demand held back by tx_en low (R8), odd buffer address (R1)
    ready_mode = 1;
    do_reset(1, 1);
    check(!tx_valid && !tx_irq && !mem_req, "R8", "reset outputs quiet",
          {tx_valid, tx_irq, mem_req}, 0);
    set_desc(0, 2049, 12, 1, 1, 1, 1);
    req_cnt = 0;
    pulse_demand();
    repeat (20) @(negedge clk);
    check(req_cnt == 0, "R8", "no access while disabled", req_cnt, 0);
    tx_en = 1'b1;
    wait_idle();
    model_pass();
    compare("R8 R1");

    // longest legal buffer, then one byte too long (R2)
    do_reset(2, 2);
    tx_en = 1'b1;
    set_desc(0, 2048, 1900, 1, 1, 1, 1);
    set_desc(1, 6000, 1901, 1, 1, 1, 1);
    run_pass("R2 length bounds");

    // bad high nibble marker (R2) and too short (R2)
    do_reset(2, 3);
    tx_en = 1'b1;
    set_desc(0, 2048, 20, 1, 1, 1, 0);
    set_desc(1, 2200, 11, 1, 1, 1, 1);
    run_pass("R2 marker");

    // ownership clear ends the pass (R3)
    do_reset(2, 4);
    tx_en = 1'b1;
    set_desc(0, 2048, 14, 1, 1, 1, 1);
    set_desc(1, 2200, 14, 0, 1, 1, 1);
    run_pass("R3 owner clear");

    // no start flag at frame head (R9)
    do_reset(2, 5);
    tx_en = 1'b1;
    set_desc(0, 2048, 14, 1, 0, 1, 1);
    set_desc(1, 2200, 14, 1, 1, 1, 1);
    run_pass("R9 missing start");

    // restart inside a chain discards earlier buffers (R10)
    ready_mode = 0;
    do_reset(3, 6);
    tx_en = 1'b1;
    set_desc(0, 2048, 15, 1, 1, 0, 1);
    set_desc(1, 2200, 16, 1, 1, 0, 1);
    set_desc(2, 2400, 13, 1, 0, 1, 1);
    run_pass("R10 restart");

    // unfinished chain left alone (R11)
    do_reset(3, 7);
    tx_en = 1'b1;
    set_desc(0, 2048, 15, 1, 1, 0, 1);
    set_desc(1, 2200, 16, 1, 0, 0, 1);
    set_desc(2, 2400, 13, 0, 0, 1, 1);
    run_pass("R11 open chain");

    // chained frame across the wrap point (R7, R4)
    do_reset(3, 8);
    tx_en = 1'b1;
    set_desc(0, 2048, 12, 1, 1, 1, 1);
    set_desc(1, 2201, 13, 1, 1, 1, 1);
    set_desc(2, 2400, 14, 0, 1, 0, 1);
    run_pass("R7 first lap");
    set_desc(2, 2400, 14, 1, 1, 0, 1);
    set_desc(0, 2047 + 2, 17, 1, 0, 1, 1);
    run_pass("R7 R4 wrap chain");

    // random rings
    for (int sc = 0; sc < 14; sc++) begin
      int L;
      L = 1 + int'($urandom % 8);
      ready_mode = (sc % 3 == 0) ? 1 : 0;
      do_reset(L, 100 + sc);
      tx_en = 1'b1;
      for (int n = 0; n < L; n++) begin
        int len, r;
        bit mark;
        r = int'($urandom % 16);
        len = 12 + int'($urandom % 10);
        if (r == 0) len = 11;
        if (r == 1) len = 1901;
        mark = (r != 2);
        set_desc(n, 2048 + n * 128 + int'($urandom % 4), len,
                 ($urandom % 8) != 0, $urandom % 2, $urandom % 2, mark);
      end
      run_pass("R4 random pass1");
      for (int n = 0; n < L; n++)
        if ($urandom % 2) set_own(n);
      run_pass("R4 R7 random pass2");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule